// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the purely combinational execute stage of a 32-bit load/store RISC pipeline. Each cycle it receives the two register operands (`rs_i`, `rt_i`), the instruction's 5-bit constant shift amount, its 16-bit immediate and an already-decoded operation code. In the same cycle it returns the result word, a flag that reports a signed-overflow trap, and a write qualifier that tells the writeback stage whether the destination register may be updated.

Inside the block, one adder handles addition, subtraction and both less-than comparisons. A single logarithmic shifter handles all six shift forms. An immediate generator extends the 16-bit field in one of three ways, chosen by the opcode: sign fill, zero fill, or placement in the upper half. The register file, multiply/divide, memory access and branch resolution all sit outside this block.

Operation codes are the `alu_op_e` enumeration in `alu_pkg`, numbered consecutively from 0: ADD, ADDU, SUB, SUBU, AND, OR, XOR, NOR, SLT, SLTU, SLL, SRL, SRA, SLLV, SRLV, SRAV, ADDI, ADDIU, SLTI, SLTIU, ANDI, ORI, XORI, LUI (0 to 23).

Top module: `alu_exec`

## Requirements
- R1: ADD, ADDU, ADDI and ADDIU return rs plus the second operand, modulo 2^32. The second operand is rt for the register forms and the extended immediate for the immediate forms.
- R2: SUB and SUBU return rs minus rt, modulo 2^32.
- R3: ovf_o is 1 only for ADD, SUB and ADDI, and only when the two's-complement result does not fit in 32 bits. ADDU, SUBU and ADDIU never raise it, even with the same operands. wr_valid_o is 0 exactly when ovf_o is 1.
- R4: AND, OR, XOR and NOR return the bitwise function of rs and rt. NOR returns the complement of (rs OR rt).
- R5: SLT returns 1 when rs < rt as signed numbers and 0 otherwise. SLTU does the same comparison as unsigned numbers. Bits 31:1 of the result are always 0.
- R6: SLTI and SLTIU first sign-extend the immediate. SLTI then compares signed. SLTIU compares the sign-extended value as unsigned.
- R7: ADDI and ADDIU sign-extend the immediate. ANDI, ORI and XORI zero-extend it, so for ANDI the result bits 31:16 are 0.
- R8: LUI returns the immediate in bits 31:16 and zeros in bits 15:0. The register operands have no effect on it.
- R9: SLL, SRL and SRA shift rt by shamt_i.
- R10: SLLV, SRLV and SRAV shift rt by the value in bits 4:0 of rs. The upper bits of rs are ignored.
- R11: Logical right shifts fill with zeros. Arithmetic right shifts fill with bit 31 of rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_i | input | 32 | First register operand; its bits 4:0 are the variable shift amount |
| rt_i | input | 32 | Second register operand; the value that shifts operate on |
| shamt_i | input | 5 | Constant shift amount taken from the instruction |
| imm_i | input | 16 | Immediate field of the instruction |
| op_i | input | 5 | Decoded operation code (alu_op_e) |
| result_o | output | 32 | Result word |
| ovf_o | output | 1 | Signed-overflow trap on a trapping add or subtract |
| wr_valid_o | output | 1 | Destination register may be written |

## Verification
The block has no state, so any internal fault shows up at `result_o`, `ovf_o` or `wr_valid_o` in the same cycle the operands are applied. Typical faults are a wrong decode bit, a swapped extension mode or a broken shifter stage. A shifter stage fault is visible only for shift amounts whose matching bit is set. An extension fault is visible only when immediate bit 15 is 1. An overflow fault is visible only at the signed limits. For that reason, the directed vectors sit on 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and 0x8000/0xFFFF immediates. The random sweep compares every opcode against a separate behavioural model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBU  = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOR   = 5'd7,
    OP_SLT   = 5'd8,
    OP_SLTU  = 5'd9,
    OP_SLL   = 5'd10,
    OP_SRL   = 5'd11,
    OP_SRA   = 5'd12,
    OP_SLLV  = 5'd13,
    OP_SRLV  = 5'd14,
    OP_SRAV  = 5'd15,
    OP_ADDI  = 5'd16,
    OP_ADDIU = 5'd17,
    OP_SLTI  = 5'd18,
    OP_SLTIU = 5'd19,
    OP_ANDI  = 5'd20,
    OP_ORI   = 5'd21,
    OP_XORI  = 5'd22,
    OP_LUI   = 5'd23
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN  = 2'd0,
    EXT_ZERO  = 2'd1,
    EXT_UPPER = 2'd2
  } imm_ext_e;

  typedef enum logic [1:0] {
    LFN_AND = 2'd0,
    LFN_OR  = 2'd1,
    LFN_XOR = 2'd2,
    LFN_NOR = 2'd3
  } logic_fn_e;

  typedef enum logic [2:0] {
    SEL_ARITH = 3'd0,
    SEL_LOGIC = 3'd1,
    SEL_LT_S  = 3'd2,
    SEL_LT_U  = 3'd3,
    SEL_SHIFT = 3'd4,
    SEL_IMM   = 3'd5,
    SEL_ZERO  = 3'd6
  } res_sel_e;

  typedef struct packed {
    res_sel_e  sel;
    logic      use_imm;
    imm_ext_e  ext;
    logic      sub;
    logic      trap;
    logic_fn_e lfn;
    logic      sh_left;
    logic      sh_arith;
    logic      sh_var;
  } alu_ctl_t;

endpackage

// File: rtl/alu_imm_gen.sv
module alu_imm_gen
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  imm_ext_e          mode_i,
  output logic [DATA_W-1:0] imm_o
);

  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    unique case (mode_i)
      EXT_ZERO:  imm_o = {{PAD_W{1'b0}}, imm_i};
      EXT_UPPER: imm_o = {imm_i, {PAD_W{1'b0}}};
      default:   imm_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o,
  output logic              lt_s_o,
  output logic              lt_u_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   full;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    full   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
    sum_o  = full[MSB:0];
    ovf_o  = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
    // signed less-than: true sign of a-b is result sign corrected by overflow
    lt_s_o = full[MSB] ^ ovf_o;
    // borrow out of a-b means a < b unsigned
    lt_u_o = sub_i & ~full[DATA_W];
  end

  always_comb begin
    // R3
    ovf_sign_chk: assert (!(ovf_o && sub_i && (a_i[MSB] == b_i[MSB])));
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_fn_e         fn_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    unique case (fn_i)
      LFN_OR:  res_o = a_i | b_i;
      LFN_XOR: res_o = a_i ^ b_i;
      LFN_NOR: res_o = ~(a_i | b_i);
      default: res_o = a_i & b_i;
    endcase
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  val_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               left_i,
  input  logic               arith_i,
  output logic [DATA_W-1:0]  res_o
);

  logic [DATA_W-1:0] stage [SHAMT_W+1];
  logic [DATA_W-1:0] val_rev;
  logic [DATA_W-1:0] out_rev;
  logic              fill;

  // left shift = reverse, shift right, reverse
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      val_rev[i] = val_i[DATA_W-1-i];
    end
  end

  assign fill     = arith_i & ~left_i & val_i[DATA_W-1];
  assign stage[0] = left_i ? val_rev : val_i;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      out_rev[i] = stage[SHAMT_W][DATA_W-1-i];
    end
  end

  assign res_o = left_i ? out_rev : stage[SHAMT_W];

  always_comb begin
    // R9
    zero_amt_chk: assert (amt_i != '0 || res_o == val_i);
  end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int  DATA_W  = 32,
  parameter int  IMM_W   = 16,
  localparam int SHAMT_W = $clog2(DATA_W),
  localparam int OP_W    = $bits(alu_op_e)
) (
  input  logic [DATA_W-1:0]  rs_i,
  input  logic [DATA_W-1:0]  rt_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [OP_W-1:0]    op_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               ovf_o,
  output logic               wr_valid_o
);

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] shift_res;
  logic [SHAMT_W-1:0] sh_amt;
  logic              raw_ovf;
  logic              lt_s;
  logic              lt_u;

  always_comb begin
    ctl = '{sel: SEL_ZERO, use_imm: 1'b0, ext: EXT_SIGN, sub: 1'b0, trap: 1'b0,
            lfn: LFN_AND, sh_left: 1'b0, sh_arith: 1'b0, sh_var: 1'b0};
    unique case (alu_op_e'(op_i))
      OP_ADD:   begin ctl.sel = SEL_ARITH; ctl.trap = 1'b1; end
      OP_ADDU:  ctl.sel = SEL_ARITH;
      OP_SUB:   begin ctl.sel = SEL_ARITH; ctl.sub = 1'b1; ctl.trap = 1'b1; end
      OP_SUBU:  begin ctl.sel = SEL_ARITH; ctl.sub = 1'b1; end
      OP_AND:   begin ctl.sel = SEL_LOGIC; ctl.lfn = LFN_AND; end
      OP_OR:    begin ctl.sel = SEL_LOGIC; ctl.lfn = LFN_OR; end
      OP_XOR:   begin ctl.sel = SEL_LOGIC; ctl.lfn = LFN_XOR; end
      OP_NOR:   begin ctl.sel = SEL_LOGIC; ctl.lfn = LFN_NOR; end
      OP_SLT:   begin ctl.sel = SEL_LT_S; ctl.sub = 1'b1; end
      OP_SLTU:  begin ctl.sel = SEL_LT_U; ctl.sub = 1'b1; end
      OP_SLL:   begin ctl.sel = SEL_SHIFT; ctl.sh_left = 1'b1; end
      OP_SRL:   ctl.sel = SEL_SHIFT;
      OP_SRA:   begin ctl.sel = SEL_SHIFT; ctl.sh_arith = 1'b1; end
      OP_SLLV:  begin ctl.sel = SEL_SHIFT; ctl.sh_left = 1'b1; ctl.sh_var = 1'b1; end
      OP_SRLV:  begin ctl.sel = SEL_SHIFT; ctl.sh_var = 1'b1; end
      OP_SRAV:  begin ctl.sel = SEL_SHIFT; ctl.sh_arith = 1'b1; ctl.sh_var = 1'b1; end
      OP_ADDI:  begin ctl.sel = SEL_ARITH; ctl.use_imm = 1'b1; ctl.trap = 1'b1; end
      OP_ADDIU: begin ctl.sel = SEL_ARITH; ctl.use_imm = 1'b1; end
      OP_SLTI:  begin ctl.sel = SEL_LT_S; ctl.use_imm = 1'b1; ctl.sub = 1'b1; end
      OP_SLTIU: begin ctl.sel = SEL_LT_U; ctl.use_imm = 1'b1; ctl.sub = 1'b1; end
      OP_ANDI:  begin ctl.sel = SEL_LOGIC; ctl.use_imm = 1'b1; ctl.ext = EXT_ZERO; ctl.lfn = LFN_AND; end
      OP_ORI:   begin ctl.sel = SEL_LOGIC; ctl.use_imm = 1'b1; ctl.ext = EXT_ZERO; ctl.lfn = LFN_OR; end
      OP_XORI:  begin ctl.sel = SEL_LOGIC; ctl.use_imm = 1'b1; ctl.ext = EXT_ZERO; ctl.lfn = LFN_XOR; end
      OP_LUI:   begin ctl.sel = SEL_IMM; ctl.ext = EXT_UPPER; end
      default:  ;
    endcase
  end

  alu_imm_gen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
    .imm_i  (imm_i),
    .mode_i (ctl.ext),
    .imm_o  (imm_ext)
  );

  assign opnd_b = ctl.use_imm ? imm_ext : rt_i;

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i    (rs_i),
    .b_i    (opnd_b),
    .sub_i  (ctl.sub),
    .sum_o  (arith_res),
    .ovf_o  (raw_ovf),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (rs_i),
    .b_i   (opnd_b),
    .fn_i  (ctl.lfn),
    .res_o (logic_res)
  );

  // variable forms take only the low bits of rs
  assign sh_amt = ctl.sh_var ? rs_i[SHAMT_W-1:0] : shamt_i;

  alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .val_i   (rt_i),
    .amt_i   (sh_amt),
    .left_i  (ctl.sh_left),
    .arith_i (ctl.sh_arith),
    .res_o   (shift_res)
  );

  always_comb begin
    unique case (ctl.sel)
      SEL_ARITH: result_o = arith_res;
      SEL_LOGIC: result_o = logic_res;
      SEL_LT_S:  result_o = {{(DATA_W-1){1'b0}}, lt_s};
      SEL_LT_U:  result_o = {{(DATA_W-1){1'b0}}, lt_u};
      SEL_SHIFT: result_o = shift_res;
      SEL_IMM:   result_o = imm_ext;
      default:   result_o = '0;
    endcase
  end

  assign ovf_o      = ctl.trap & raw_ovf;
  assign wr_valid_o = ~ovf_o;

  always_comb begin
    // R3
    trap_op_chk: assert (!ovf_o || op_i == OP_ADD || op_i == OP_SUB || op_i == OP_ADDI);
    // R5
    lt_bool_chk: assert (!(op_i == OP_SLT || op_i == OP_SLTU || op_i == OP_SLTI || op_i == OP_SLTIU)
                         || result_o[DATA_W-1:1] == '0);
    // R8
    upper_low_chk: assert (op_i != OP_LUI || result_o == {imm_i, {(DATA_W-IMM_W){1'b0}}});
    // R7
    zext_hi_chk: assert (op_i != OP_ANDI || result_o[DATA_W-1:IMM_W] == '0);
    // R11
    sra_fill_chk: assert (!(op_i == OP_SRA && rt_i[DATA_W-1]) || result_o[DATA_W-1]);
  end

endmodule

// File: tb/tb_alu_exec.sv
module tb_alu_exec;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] rs, rt, res;
  logic [4:0]  sh, op;
  logic [15:0] imm;
  logic        ovf, wv;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  alu_exec dut (
    .rs_i(rs), .rt_i(rt), .shamt_i(sh), .imm_i(imm), .op_i(op),
    .result_o(res), .ovf_o(ovf), .wr_valid_o(wv)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] rs;
    logic [31:0] rt;
    logic [4:0]  sh;
    logic [15:0] imm;
    logic [31:0] exp;
    logic        eovf;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{OP_ADD,   32'h7fffffff, 32'h00000001, 5'd0,  16'h0000, 32'h80000000, 1'b1, 4'd3 },  // R3
    '{OP_ADDU,  32'h7fffffff, 32'h00000001, 5'd0,  16'h0000, 32'h80000000, 1'b0, 4'd1 },  // R1
    '{OP_SUB,   32'h80000000, 32'h00000001, 5'd0,  16'h0000, 32'h7fffffff, 1'b1, 4'd3 },  // R3
    '{OP_SUBU,  32'h00000000, 32'h00000001, 5'd0,  16'h0000, 32'hffffffff, 1'b0, 4'd2 },  // R2
    '{OP_ADD,   32'hffffffff, 32'hffffffff, 5'd0,  16'h0000, 32'hfffffffe, 1'b0, 4'd1 },  // R1
    '{OP_NOR,   32'h0f0f0000, 32'h00f0ffff, 5'd0,  16'h0000, 32'hf0000000, 1'b0, 4'd4 },  // R4
    '{OP_XOR,   32'hffffffff, 32'h12345678, 5'd0,  16'h0000, 32'hedcba987, 1'b0, 4'd4 },  // R4
    '{OP_SLT,   32'h80000000, 32'h00000001, 5'd0,  16'h0000, 32'h00000001, 1'b0, 4'd5 },  // R5
    '{OP_SLTU,  32'h80000000, 32'h00000001, 5'd0,  16'h0000, 32'h00000000, 1'b0, 4'd5 },  // R5
    '{OP_SLTIU, 32'h00000005, 32'h00000000, 5'd0,  16'hffff, 32'h00000001, 1'b0, 4'd6 },  // R6
    '{OP_SLTI,  32'h00000000, 32'h00000000, 5'd0,  16'h8000, 32'h00000000, 1'b0, 4'd6 },  // R6
    '{OP_ADDIU, 32'h00000010, 32'h00000000, 5'd0,  16'hffff, 32'h0000000f, 1'b0, 4'd7 },  // R7
    '{OP_ORI,   32'h00000000, 32'h00000000, 5'd0,  16'h8000, 32'h00008000, 1'b0, 4'd7 },  // R7
    '{OP_ANDI,  32'hffffffff, 32'h00000000, 5'd0,  16'hffff, 32'h0000ffff, 1'b0, 4'd7 },  // R7
    '{OP_LUI,   32'hffffffff, 32'hffffffff, 5'd0,  16'habcd, 32'habcd0000, 1'b0, 4'd8 },  // R8
    '{OP_SLL,   32'h00000000, 32'h00000001, 5'd31, 16'h0000, 32'h80000000, 1'b0, 4'd9 },  // R9
    '{OP_SRA,   32'h00000000, 32'h80000000, 5'd4,  16'h0000, 32'hf8000000, 1'b0, 4'd11},  // R11
    '{OP_SRL,   32'h00000000, 32'h80000000, 5'd4,  16'h0000, 32'h08000000, 1'b0, 4'd11},  // R11
    '{OP_SRLV,  32'h00000024, 32'hffffffff, 5'd0,  16'h0000, 32'h0fffffff, 1'b0, 4'd10},  // R10
    '{OP_SRAV,  32'hffffffff, 32'h80000000, 5'd0,  16'h0000, 32'hffffffff, 1'b0, 4'd10},  // R10
    '{OP_ADDI,  32'h7fffffff, 32'h00000000, 5'd0,  16'h0001, 32'h80000000, 1'b1, 4'd3 },  // R3
    '{OP_ADDI,  32'h80000000, 32'h00000000, 5'd0,  16'hffff, 32'h7fffffff, 1'b1, 4'd3 },  // R3
    '{OP_SLLV,  32'h00000021, 32'h00000003, 5'd7,  16'h0000, 32'h00000006, 1'b0, 4'd10}   // R10
  };

  task automatic check(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] s, input logic [15:0] i);
    @(posedge clk);
    op = o; rs = a; rt = b; sh = s; imm = i;
    @(negedge clk);
  endtask

  function automatic void ref_model(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                                    input logic [4:0] s, input logic [15:0] i,
                                    output logic [31:0] r, output logic v);
    logic [31:0] se, ze;
    longint      wide;
    se = {{16{i[15]}}, i};
    ze = {16'h0, i};
    v  = 1'b0;
    r  = '0;
    case (alu_op_e'(o))
      OP_ADD, OP_ADDU: begin r = a + b;  wide = longint'($signed(a)) + longint'($signed(b)); v = (o == OP_ADD) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
      OP_SUB, OP_SUBU: begin r = a - b;  wide = longint'($signed(a)) - longint'($signed(b)); v = (o == OP_SUB) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
      OP_ADDI, OP_ADDIU: begin r = a + se; wide = longint'($signed(a)) + longint'($signed(se)); v = (o == OP_ADDI) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
      OP_AND:   r = a & b;
      OP_OR:    r = a | b;
      OP_XOR:   r = a ^ b;
      OP_NOR:   r = ~(a | b);
      OP_SLT:   r = {31'b0, $signed(a) < $signed(b)};
      OP_SLTU:  r = {31'b0, a < b};
      OP_SLTI:  r = {31'b0, $signed(a) < $signed(se)};
      OP_SLTIU: r = {31'b0, a < se};
      OP_ANDI:  r = a & ze;
      OP_ORI:   r = a | ze;
      OP_XORI:  r = a ^ ze;
      OP_LUI:   r = {i, 16'h0};
      OP_SLL:   r = b << s;
      OP_SRL:   r = b >> s;
      OP_SRA:   r = $unsigned($signed(b) >>> s);
      OP_SLLV:  r = b << a[4:0];
      OP_SRLV:  r = b >> a[4:0];
      OP_SRAV:  r = $unsigned($signed(b) >>> a[4:0]);
      default:  r = '0;
    endcase
  endfunction

  function automatic int req_of(input logic [4:0] o);
    case (alu_op_e'(o))
      OP_ADD, OP_SUB, OP_ADDI: return 3;
      OP_ADDU, OP_ADDIU:       return 1;
      OP_SUBU:                 return 2;
      OP_AND, OP_OR, OP_XOR, OP_NOR: return 4;
      OP_SLT, OP_SLTU:         return 5;
      OP_SLTI, OP_SLTIU:       return 6;
      OP_ANDI, OP_ORI, OP_XORI: return 7;
      OP_LUI:                  return 8;
      OP_SLL, OP_SRL, OP_SRA:  return 9;
      default:                 return 10;
    endcase
  endfunction

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h7fffffff;
      1: return 32'h80000000;
      2: return 32'hffffffff;
      3: return 32'h00000000;
      4: return 32'h00000001;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] er;
    logic        eo;
    op = OP_ADD; rs = '0; rt = '0; sh = '0; imm = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R1 idle state: all-zero operands
    @(negedge clk);
    check(1, "idle result", res, 32'h0);
    check(3, "idle ovf", {31'b0, ovf}, 32'h0);
    check(3, "idle wr_valid", {31'b0, wv}, 32'h1);

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].op, VECS[k].rs, VECS[k].rt, VECS[k].sh, VECS[k].imm);
      check(VECS[k].req, $sformatf("vec %0d result", k), res, VECS[k].exp);
      check(3, $sformatf("vec %0d ovf", k), {31'b0, ovf}, {31'b0, VECS[k].eovf});
      check(3, $sformatf("vec %0d wr_valid", k), {31'b0, wv}, {31'b0, ~VECS[k].eovf});
    end

    // R3 same operands through the non-trapping forms never flag
    apply(OP_SUBU, 32'h80000000, 32'h00000001, 5'd0, 16'h0);
    check(3, "subu no trap", {31'b0, ovf}, 32'h0);
    apply(OP_ADDIU, 32'h7fffffff, 32'h0, 5'd0, 16'h0001);
    check(3, "addiu no trap", {31'b0, ovf}, 32'h0);
    // R10 upper rs bits ignored
    apply(OP_SLLV, 32'hffffffe0, 32'h12345678, 5'd9, 16'h0);
    check(10, "sllv rs upper ignored", res, 32'h12345678);
    // R9 constant shift ignores rs
    apply(OP_SRL, 32'h0000001f, 32'hf0000000, 5'd28, 16'h0);
    check(9, "srl const", res, 32'h0000000f);

    for (int k = 0; k < 400; k++) begin
      logic [4:0]  o;
      logic [31:0] a, b;
      logic [4:0]  s;
      logic [15:0] i;
      o = 5'($urandom_range(0, 23));
      a = pick();
      b = pick();
      s = 5'($urandom);
      i = ($urandom_range(0, 3) == 0) ? 16'h8000 : 16'($urandom);
      apply(o, a, b, s, i);
      ref_model(o, a, b, s, i, er, eo);
      check(req_of(o), $sformatf("rand op %0d result", o), res, er);
      check(3, $sformatf("rand op %0d ovf", o), {31'b0, ovf}, {31'b0, eo});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule